// File: doc/BRIEF.md
# I2S Bit-Clock Prescaler

This block turns a fast source clock into the serial bit clock of an audio link. An integer divider sets the ratio. With the odd option clear, the ratio is twice the divider value. With it set, the ratio is twice the value plus one, and the extra source cycle goes into the high phase. The block also gives a one-cycle strobe in the source domain at each falling edge of the bit clock, so a serializer on the same clock can shift data without a second clock domain. A master clock output runs at half the source rate when its enable is set; otherwise it is held low.

The divider value, the odd option and the master-clock enable are sampled on every clock edge while the block is stopped. They are frozen while it runs. A divider value of 0 or 1 is illegal. If the block is started with such a value, it raises an error flag and produces no clock until it is stopped again.

The control core is a four-state machine. IDLE is the stopped state. LOW and HIGH are the two halves of the bit-clock period. FAULT is the state for an illegal setting. The transitions are:
- start: IDLE to LOW, when enabled with a legal value.
- reject: IDLE to FAULT, when enabled with an illegal value.
- rise: LOW to HIGH, when the low phase count runs out.
- fall: HIGH to LOW, when the high phase count runs out. This transition fires the strobe.
- stop: any state to IDLE, when the enable drops.

Top module: `i2s_clk_prescaler`

## Requirements
- R1: While reset is held, and on the first sample after it is released, bclk_o, bclk_fall_o, mclk_o and cfg_err_o are 0. Reset loads a divider of 2, odd clear and master clock disabled, so a block enabled straight out of reset makes a 4-cycle period, whatever div_i shows.
- R2: With odd_i = 0, the bit-clock period is 2*div source cycles, with div cycles high and div cycles low.
- R3: With odd_i = 1, the high phase lasts div+1 source cycles and the low phase lasts div cycles.
- R4: bclk_o idles low. After enable is sampled high, bclk_o stays low for exactly div cycles, then rises.
- R5: bclk_fall_o is high for exactly one cycle: the first cycle in which bclk_o is low after being high. It is low at all other times.
- R6: A latched divider of 0 or 1 at start sets cfg_err_o high for as long as the block stays enabled. bclk_o, bclk_fall_o and mclk_o stay low during that time.
- R7: Changes to div_i, odd_i and mclk_en_i while en_i is high have no effect on any output until the block is stopped.
- R8: One cycle after en_i is sampled low, bclk_o and bclk_fall_o are 0. The phase counter is cleared, so a restart again waits a full div cycles before the first rise.
- R9: While running with the latched master-clock enable set, mclk_o is 0 in the first cycle and then inverts on every source cycle. With the enable clear, mclk_o stays 0.
- R10: The largest setting, div = 255 with odd set, gives a 256-cycle high phase and a 255-cycle low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; settings are sampled while it is low |
| div_i | input | 8 | Linear divider value; 0 and 1 are illegal |
| odd_i | input | 1 | Adds one source cycle to the period (in the high phase) |
| mclk_en_i | input | 1 | Master clock output enable |
| bclk_o | output | 1 | Divided bit clock, idle low |
| bclk_fall_o | output | 1 | One-cycle strobe at each falling edge of bclk_o |
| mclk_o | output | 1 | Master clock, half the source rate when enabled |
| cfg_err_o | output | 1 | Illegal divider value seen at start |

## Verification
The bench measures the delay to the first rise, the high run and the low run for even and odd ratios, from the smallest legal divider up to 255 with odd set. An off-by-one counter would show up as a short or long phase. Putting the odd cycle in the wrong phase would swap the high and low lengths. The bench enables the block with divider values 0 and 1, where a missing range check would let a clock run with no error flag. It holds enable high through reset, which exposes a design that ignores the reset value of the divider. It changes the settings in mid-run, which catches a latch that keeps loading while the block runs. It also stops the block in its high phase and restarts it, which exposes a phase counter that is not cleared. In every run, the bench checks the strobe against the bit-clock falling edges and checks that the master clock inverts on each cycle.

// File: rtl/i2sp_pkg.sv
package i2sp_pkg;

    // Phases of the bit-clock generator
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOW   = 2'd1,
        S_HIGH  = 2'd2,
        S_FAULT = 2'd3
    } bck_state_e;

    // Smallest legal divider value
    localparam int unsigned DIV_MIN = 2;

endpackage

// File: rtl/i2sp_cfg_latch.sv
module i2sp_cfg_latch #(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned RST_DIV = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             mclk_en_i,
    output logic [DIV_W-1:0] div_q,
    output logic             odd_q,
    output logic             mclk_en_q,
    output logic             bad_q
);
    import i2sp_pkg::*;

    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

    // Settings follow the inputs only while the block is stopped
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q     <= RST_VAL;
            odd_q     <= 1'b0;
            mclk_en_q <= 1'b0;
        end else if (!en_i) begin
            div_q     <= div_i;
            odd_q     <= odd_i;
            mclk_en_q <= mclk_en_i;
        end
    end

    assign bad_q = (div_q < DIV_W'(DIV_MIN));

    // R7
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i) |-> ($stable(div_q) && $stable(odd_q) && $stable(mclk_en_q)));

endmodule

// File: rtl/i2sp_phase_fsm.sv
module i2sp_phase_fsm #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             bad_i,
    output logic             bclk_o,
    output logic             fall_o,
    output logic             err_o,
    output logic             run_o
);
    import i2sp_pkg::*;

    localparam int unsigned CW = DIV_W + 1;

    bck_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           fall_q, fall_d;
    logic [CW-1:0]  lo_len, hi_len, cur_len;
    logic           last;

    assign lo_len  = {1'b0, div_i};
    assign hi_len  = {1'b0, div_i} + CW'(odd_i);
    assign cur_len = (state_q == S_HIGH) ? hi_len : lo_len;
    assign last    = (cnt_q == cur_len - CW'(1));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            fall_q  <= fall_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        fall_d  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (en_i) state_d = bad_i ? S_FAULT : S_LOW;
            end
            S_FAULT: begin
                if (!en_i) state_d = S_IDLE;
            end
            S_LOW: begin
                if (!en_i) begin
                    state_d = S_IDLE;
                end else if (last) begin
                    state_d = S_HIGH;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            S_HIGH: begin
                if (!en_i) begin
                    state_d = S_IDLE;
                end else if (last) begin
                    state_d = S_LOW;
                    fall_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bclk_o = 1'b0;
        err_o  = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_LOW:   run_o = 1'b1;
            S_HIGH:  begin bclk_o = 1'b1; run_o = 1'b1; end
            S_FAULT: err_o = 1'b1;
            default: ;
        endcase
    end
    assign fall_o = fall_q;

    // R5
    fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!bclk_o && $past(bclk_o)));

    // R6
    fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $past(bad_i));

    // R8
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> (!bclk_o && !fall_o && !err_o));

    // R3
    phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_HIGH) |-> (cnt_q < hi_len));

endmodule

// File: rtl/i2sp_mclk_gen.sv
module i2sp_mclk_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic mclk_en_i,
    output logic mclk_o
);
    logic mclk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 mclk_q <= 1'b0;
        else if (run_i && mclk_en_i) mclk_q <= ~mclk_q;
        else                         mclk_q <= 1'b0;
    end

    assign mclk_o = mclk_q;

    // R9
    mclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_o |=> !mclk_o);

    // R9
    mclk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mclk_en_i |=> !mclk_o);

endmodule

// File: rtl/i2s_clk_prescaler.sv
module i2s_clk_prescaler #(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned RST_DIV = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             mclk_en_i,
    output logic             bclk_o,
    output logic             bclk_fall_o,
    output logic             mclk_o,
    output logic             cfg_err_o
);
    logic [DIV_W-1:0] div_q;
    logic             odd_q, mclk_en_q, bad_q, run;

    i2sp_cfg_latch #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .div_i     (div_i),
        .odd_i     (odd_i),
        .mclk_en_i (mclk_en_i),
        .div_q     (div_q),
        .odd_q     (odd_q),
        .mclk_en_q (mclk_en_q),
        .bad_q     (bad_q)
    );

    i2sp_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .div_i  (div_q),
        .odd_i  (odd_q),
        .bad_i  (bad_q),
        .bclk_o (bclk_o),
        .fall_o (bclk_fall_o),
        .err_o  (cfg_err_o),
        .run_o  (run)
    );

    i2sp_mclk_gen u_mclk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .mclk_en_i (mclk_en_q),
        .mclk_o    (mclk_o)
    );

    // R6
    fault_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!bclk_o && !bclk_fall_o && !mclk_o));

endmodule

// File: tb/i2s_clk_prescaler_test.sv
module i2s_clk_prescaler_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 9;
    // {mclk_en[9], odd[8], div[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        10'h002, 10'h302, 10'h003, 10'h103, 10'h207,
        10'h10A, 10'h000, 10'h101, 10'h1FF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div = 8'd0;
    logic       odd = 1'b0;
    logic       mclk_en = 1'b0;
    logic       bclk, bfall, mclk, err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // measurement results
    int t_rise, t_high, t_low, strobe_bad, mclk_bad, err_seen, phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_clk_prescaler uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .odd_i(odd),
        .mclk_en_i(mclk_en), .bclk_o(bclk), .bclk_fall_o(bfall),
        .mclk_o(mclk), .cfg_err_o(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples ncyc negedges after enable; optionally tampers with settings
    task automatic measure(input int ncyc, input bit exp_m, input bit tamper);
        bit pb, pm;
        int run;
        t_rise = -1; t_high = -1; t_low = -1;
        strobe_bad = 0; mclk_bad = 0; err_seen = 0; phase = 0;
        pb = 1'b0; pm = 1'b0; run = 0;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (bfall != (pb && !bclk)) strobe_bad++;
            if (i == 1 || !exp_m) begin
                if (mclk) mclk_bad++;
            end else if (mclk == pm) mclk_bad++;
            if (err) err_seen++;
            case (phase)
                0: if (bclk) begin t_rise = i - 1; phase = 1; run = 1; end
                1: if (bclk) run++; else begin t_high = run; phase = 2; run = 1; end
                2: if (!bclk) run++; else begin t_low = run; phase = 3; end
                default: ;
            endcase
            pb = bclk; pm = mclk;
            if (tamper && i == 1) begin
                div = 8'd9; odd = 1'b1; mclk_en = 1'b1;
            end
        end
    endtask

    task automatic start(input logic [7:0] d, input bit o, input bit m);
        @(negedge clk);
        en = 1'b0; div = d; odd = o; mclk_en = m;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic stop_and_check(input string req);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(req, {bclk, bfall, err}, 0);
    endtask

    initial begin
        // R1: enable held through reset with a large div_i on the inputs
        en = 1'b1; div = 8'd5;
        repeat (3) @(negedge clk);
        check("R1 bclk in reset", bclk, 0);
        check("R1 outputs in reset", {bfall, mclk, err}, 0);
        rst_n = 1'b1;
        measure(12, 1'b0, 1'b0);
        check("R1 rise after reset divider", t_rise, 2);
        check("R1 high phase", t_high, 2);
        check("R1 low phase", t_low, 2);
        stop_and_check("R8 stop after reset run");

        // Table walk: R2 R3 R4 R5 R6 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            int d, o, m, nc;
            bit good;
            d = int'(VEC[v][7:0]); o = int'(VEC[v][8]); m = int'(VEC[v][9]);
            good = (d >= 2);
            nc = good ? (d + 2*(d + o) + d + 3) : 20;
            start(VEC[v][7:0], VEC[v][8], VEC[v][9]);
            measure(nc, good && (m != 0), 1'b0);
            if (good) begin
                check("R4 first rise delay", t_rise, d);
                check(o ? "R3 odd high phase" : "R2 even high phase", t_high, d + o);
                check(d == 255 ? "R10 max low phase" : "R2 low phase", t_low, d);
                check("R6 no error for legal div", err_seen, 0);
            end else begin
                check("R6 error flag held", err_seen, nc);
                check("R6 no bit clock", phase, 0);
            end
            check("R5 strobe alignment", strobe_bad, 0);
            check("R9 master clock", mclk_bad, 0);
            stop_and_check("R8 outputs idle after stop");
        end

        // R7: settings changed mid-run are ignored
        start(8'd3, 1'b0, 1'b0);
        measure(3 + 6 + 3 + 3, 1'b0, 1'b1);
        check("R7 rise unchanged", t_rise, 3);
        check("R7 high unchanged", t_high, 3);
        check("R7 low unchanged", t_low, 3);
        check("R7 master clock stays off", mclk_bad, 0);
        stop_and_check("R8 stop after tamper");

        // R8: stop inside the high phase, restart, counter cleared
        start(8'd4, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check("R8 in high phase before stop", bclk, 1);
        en = 1'b0;
        @(negedge clk);
        check("R8 bclk low one cycle after stop", bclk, 0);
        check("R8 no strobe on stop", bfall, 0);
        en = 1'b1;
        measure(4 + 8 + 4 + 3, 1'b0, 1'b0);
        check("R8 restart waits full half period", t_rise, 4);
        check("R8 restart high", t_high, 4);
        stop_and_check("R8 final stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule